// File: doc/BRIEF.md
# Memory Image Rotation Engine

This block turns a character image held in external memory by 180 degrees. Each character is one 32-bit word. The image is a stack of fixed-length lines. The block drives two AXI4 master channel sets, one for reads and one for writes. A rising edge on the start input begins a run.

For every line, the engine issues one incrementing read burst that covers the whole line and captures the words in a local line buffer. It then issues one write burst that sends the same words back in reverse order into the output region. Source lines are visited at ascending offsets. Destination line slots are visited at descending offsets, starting with the highest slot. This inverts both the order of the lines and the order of the characters within each line.

A write is counted as complete only when an OKAY write response arrives. Any other response causes the same burst to be written again from the buffer. Between two lines the block pulses a next-line request. After the final line it raises a done flag, which stays high until the next start edge. Each channel adds its own base address to the offset the engine generates.

Top module: `img_rot_engine`

## Requirements
- R1: While reset is held and directly after it, the AR, AW and W valid outputs, RREADY, BREADY, the next-line request and done are all low.
- R2: A run starts only on a low-to-high transition of `start_i` seen while idle. A start level held high after a run, or a start edge during a run, issues no extra read burst.
- R3: The read burst for source line k (k from 0) has address `rd_base_i + IN_OFF + k*LINE_BYTES`, where LINE_BYTES = WORDS*4 (0x100 by default). It has length field WORDS-1 (63), size field 2 (4 bytes) and burst field 2'b01 (INCR).
- R4: The write burst for source line k goes to `wr_base_i + OUT_OFF + (LINES-1-k)*LINE_BYTES`, so the first run writes offset 0x2F00 first and offset 0x1800 last. Its length, size and burst fields match R3.
- R5: Write beat j (0-based) of a line carries the data of read beat WORDS-1-j of that line. WSTRB is all ones, and WLAST is high only on beat WORDS-1.
- R6: Reads and writes strictly alternate. The read burst of a line is issued only after the previous line got its OKAY write response. The write address is issued only after all read beats of the line were taken.
- R7: A write response other than OKAY (BRESP 2'b00) makes the engine reissue the write burst of the same line, at the same address and with the same data. The line is not counted.
- R8: After each OKAY response that is followed by another line, `next_line_o` is high for one cycle, and ARVALID of the next line is high in that same cycle. A run of LINES lines gives LINES-1 pulses.
- R9: After the OKAY response of the last line, `done_o` rises and stays high until the next accepted start edge, which clears it. A new edge then runs the whole image again.
- R10: While a valid is high and its ready is low, the AR and W channels hold valid and their address or data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run request; rising edge starts |
| rd_base_i | input | ADDR_W | Base added to read offsets |
| wr_base_i | input | ADDR_W | Base added to write offsets |
| m_araddr | output | ADDR_W | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte enables |
| m_wlast | output | 1 | Final write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| next_line_o | output | 1 | One-cycle request for the next line |
| done_o | output | 1 | Sticky completion flag |

## Verification
The checks assume the memory side behaves properly: read data beats arrive only after a read address was accepted, and exactly WORDS of them arrive per burst. A write response arrives only after the last write beat. Both base inputs stay still during a run. The bench's responder meets these assumptions by construction. It keeps a count of pending beats and a pending-response flag, and it changes the bases only while the engine is idle. Inside those limits, the responder stalls every ready and valid from a shift register and injects one error response.

// File: rtl/img_rot_pkg.sv
package img_rot_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AREQ,
      ST_RDAT,
      ST_AWREQ,
      ST_WDAT,
      ST_BRSP
   } rot_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/img_rot_linebuf.sv
module img_rot_linebuf #(
   parameter  int DATA_W      = 32,
   parameter  int DEPTH       = 64,
   parameter  bit REV_ON_FILL = 1'b0,
   localparam int IDX_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  put_idx;
   logic [IDX_W-1:0]  get_idx;

   // Reversal happens either when storing or when fetching; same result.
   generate
      if (REV_ON_FILL) begin : g_rev_fill
         assign put_idx = TOP_IDX - wr_idx_i;
         assign get_idx = rd_idx_i;
      end else begin : g_rev_drain
         assign put_idx = wr_idx_i;
         assign get_idx = TOP_IDX - rd_idx_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) mem[put_idx] <= wr_data_i;
   end

   assign rd_data_o = mem[get_idx];
endmodule

// File: rtl/img_rot_addr.sv
module img_rot_addr #(
   parameter int ADDR_W     = 32,
   parameter int LINES      = 24,
   parameter int LINE_BYTES = 256,
   parameter int IN_OFF     = 0,
   parameter int OUT_OFF    = 'h1800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] rd_base_i,
   input  logic [ADDR_W-1:0] wr_base_i,
   output logic [ADDR_W-1:0] araddr_o,
   output logic [ADDR_W-1:0] awaddr_o
);
   localparam logic [ADDR_W-1:0] RD_FIRST = ADDR_W'(IN_OFF);
   localparam logic [ADDR_W-1:0] RD_END   = ADDR_W'(IN_OFF + LINES * LINE_BYTES);
   localparam logic [ADDR_W-1:0] WR_FLOOR = ADDR_W'(OUT_OFF);
   localparam logic [ADDR_W-1:0] WR_FIRST = ADDR_W'(OUT_OFF + (LINES - 1) * LINE_BYTES);
   localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(LINE_BYTES);

   logic [ADDR_W-1:0] rd_off_q;
   logic [ADDR_W-1:0] wr_off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_off_q <= RD_FIRST;
         wr_off_q <= WR_FIRST;
      end else if (load_i) begin
         rd_off_q <= RD_FIRST;
         wr_off_q <= WR_FIRST;
      end else if (step_i) begin
         rd_off_q <= rd_off_q + STRIDE;
         wr_off_q <= wr_off_q - STRIDE;
      end
   end

   assign araddr_o = rd_base_i + rd_off_q;
   assign awaddr_o = wr_base_i + wr_off_q;

   AST_RD_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      rd_off_q >= RD_FIRST && rd_off_q < RD_END) else $error("read offset left region"); // R3
   AST_WR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off_q >= WR_FLOOR && wr_off_q <= WR_FIRST) else $error("write offset left region"); // R4
endmodule

// File: rtl/img_rot_seq.sv
module img_rot_seq
   import img_rot_pkg::*;
#(
   parameter  int WORDS  = 64,
   parameter  int LINES  = 24,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ar_ready_i,
   input  logic             r_valid_i,
   input  logic             aw_ready_i,
   input  logic             w_ready_i,
   input  logic             b_valid_i,
   input  logic [1:0]       b_resp_i,
   output logic             ar_valid_o,
   output logic             r_ready_o,
   output logic             aw_valid_o,
   output logic             w_valid_o,
   output logic             w_last_o,
   output logic             b_ready_o,
   output logic [IDX_W-1:0] beat_o,
   output logic             fill_o,
   output logic             load_o,
   output logic             step_o,
   output logic             next_line_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0]  LAST_BEAT = IDX_W'(WORDS - 1);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   rot_state_e        state_q;
   logic [IDX_W-1:0]  beat_q;
   logic [LINE_W-1:0] line_q;
   logic              start_q;
   logic              done_q;
   logic              nl_q;
   logic              rise;
   logic              resp_ok;

   assign rise    = start_i & ~start_q;
   assign resp_ok = b_valid_i && (b_resp_i == RESP_OKAY);

   always_comb begin
      ar_valid_o  = (state_q == ST_AREQ);
      r_ready_o   = (state_q == ST_RDAT);
      aw_valid_o  = (state_q == ST_AWREQ);
      w_valid_o   = (state_q == ST_WDAT);
      b_ready_o   = (state_q == ST_BRSP);
      w_last_o    = w_valid_o && (beat_q == LAST_BEAT);
      fill_o      = r_ready_o && r_valid_i;
      load_o      = (state_q == ST_IDLE) && rise;
      step_o      = b_ready_o && resp_ok && (line_q != LAST_LINE);
      beat_o      = beat_q;
      next_line_o = nl_q;
      done_o      = done_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         line_q  <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         nl_q    <= 1'b0;
      end else begin
         start_q <= start_i;
         nl_q    <= 1'b0;
         case (state_q)
            ST_IDLE: if (rise) begin
               state_q <= ST_AREQ;
               line_q  <= '0;
               done_q  <= 1'b0;
            end
            ST_AREQ: if (ar_ready_i) begin
               state_q <= ST_RDAT;
               beat_q  <= '0;
            end
            ST_RDAT: if (r_valid_i) begin
               if (beat_q == LAST_BEAT) begin
                  beat_q  <= '0;
                  state_q <= ST_AWREQ;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            ST_AWREQ: if (aw_ready_i) begin
               state_q <= ST_WDAT;
               beat_q  <= '0;
            end
            ST_WDAT: if (w_ready_i) begin
               if (beat_q == LAST_BEAT) begin
                  beat_q  <= '0;
                  state_q <= ST_BRSP;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            ST_BRSP: if (b_valid_i) begin
               if (!resp_ok) begin
                  state_q <= ST_AWREQ;
               end else if (line_q == LAST_LINE) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  line_q  <= line_q + 1'b1;
                  nl_q    <= 1'b1;
                  state_q <= ST_AREQ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HELD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_q) |=> !ar_valid_o) else $error("level restarted engine"); // R2
   AST_READ_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ar_valid_o) |-> ($past(b_valid_i && b_ready_o && b_resp_i == RESP_OKAY) || $past(load_o)))
      else $error("read issued without prior OKAY"); // R6
   AST_RETRY_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid_i && b_ready_o && b_resp_i != RESP_OKAY) |=> aw_valid_o) else $error("no retry"); // R7
   AST_NEXT_LINE_AR: assert property (@(posedge clk) disable iff (!rst_n)
      next_line_o |-> (ar_valid_o && $past(resp_ok))) else $error("stray next-line pulse"); // R8
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !(start_i && !start_q)) |=> done_o) else $error("done dropped"); // R9
endmodule

// File: rtl/img_rot_engine.sv
module img_rot_engine
   import img_rot_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WORDS       = 64,
   parameter int LINES       = 24,
   parameter int IN_OFF      = 0,
   parameter int OUT_OFF     = 'h1800,
   parameter bit REV_ON_FILL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   rd_base_i,
   input  logic [ADDR_W-1:0]   wr_base_i,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [7:0]          m_arlen,
   output logic [2:0]          m_arsize,
   output logic [1:0]          m_arburst,
   output logic                m_arvalid,
   input  logic                m_arready,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic                m_rvalid,
   output logic                m_rready,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [7:0]          m_awlen,
   output logic [2:0]          m_awsize,
   output logic [1:0]          m_awburst,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wlast,
   output logic                m_wvalid,
   input  logic                m_wready,
   input  logic [1:0]          m_bresp,
   input  logic                m_bvalid,
   output logic                m_bready,
   output logic                next_line_o,
   output logic                done_o
);
   localparam int BYTES_W    = DATA_W / 8;
   localparam int LINE_BYTES = WORDS * BYTES_W;
   localparam int IDX_W      = $clog2(WORDS);

   generate
      if (WORDS < 2 || WORDS > 256) begin : g_bad_words
         $error("WORDS must fit one AXI4 burst");
      end
      if (LINES < 2) begin : g_bad_lines
         $error("LINES must be at least 2");
      end
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two bytes");
      end
      if (OUT_OFF < IN_OFF + LINES * LINE_BYTES) begin : g_overlap
         $error("output region overlaps input region");
      end
   endgenerate

   logic [IDX_W-1:0] beat;
   logic             fill;
   logic             load;
   logic             step;

   img_rot_seq #(.WORDS(WORDS), .LINES(LINES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .ar_ready_i (m_arready),
      .r_valid_i  (m_rvalid),
      .aw_ready_i (m_awready),
      .w_ready_i  (m_wready),
      .b_valid_i  (m_bvalid),
      .b_resp_i   (m_bresp),
      .ar_valid_o (m_arvalid),
      .r_ready_o  (m_rready),
      .aw_valid_o (m_awvalid),
      .w_valid_o  (m_wvalid),
      .w_last_o   (m_wlast),
      .b_ready_o  (m_bready),
      .beat_o     (beat),
      .fill_o     (fill),
      .load_o     (load),
      .step_o     (step),
      .next_line_o(next_line_o),
      .done_o     (done_o)
   );

   img_rot_addr #(
      .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
      .IN_OFF(IN_OFF), .OUT_OFF(OUT_OFF)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (step),
      .rd_base_i(rd_base_i),
      .wr_base_i(wr_base_i),
      .araddr_o (m_araddr),
      .awaddr_o (m_awaddr)
   );

   img_rot_linebuf #(.DATA_W(DATA_W), .DEPTH(WORDS), .REV_ON_FILL(REV_ON_FILL)) u_buf (
      .clk      (clk),
      .we_i     (fill),
      .wr_idx_i (beat),
      .wr_data_i(m_rdata),
      .rd_idx_i (beat),
      .rd_data_o(m_wdata)
   );

   assign m_arlen   = 8'(WORDS - 1);
   assign m_awlen   = 8'(WORDS - 1);
   assign m_arsize  = 3'($clog2(BYTES_W));
   assign m_awsize  = 3'($clog2(BYTES_W));
   assign m_arburst = BURST_INCR;
   assign m_awburst = BURST_INCR;
   assign m_wstrb   = '1;

   AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr))) else $error("AR changed under stall"); // R10
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast))) else $error("W changed under stall"); // R10
   AST_NO_MIXED_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      m_rready |-> !(m_awvalid || m_wvalid || m_bready)) else $error("read and write overlap"); // R6
endmodule

// File: tb/img_rot_engine_bench.sv
module img_rot_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 64;
   localparam int LINES      = 24;
   localparam int LB         = WORDS * 4;
   localparam int OUT_OFF    = 'h1800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] rd_base = 32'h0;
   logic [31:0] wr_base = 32'h0;
   logic [31:0] m_araddr, m_awaddr, m_wdata;
   logic [7:0]  m_arlen, m_awlen;
   logic [2:0]  m_arsize, m_awsize;
   logic [1:0]  m_arburst, m_awburst;
   logic        m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
   logic [3:0]  m_wstrb;
   logic        m_next_line, m_done;
   logic        m_arready = 1'b0, m_rvalid = 1'b0, m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
   logic [31:0] m_rdata = 32'h0;
   logic [1:0]  m_bresp = 2'b00;

   int n_vec = 0, n_bad = 0;
   int exp_line = 0, ar_fires = 0, aw_fires = 0, nl_pulses = 0;
   bit stall = 1'b0, inject = 1'b0, injected = 1'b0, done_seen = 1'b0;
   bit rd_active = 1'b0, line_busy = 1'b0, b_pending = 1'b0;
   int rbeat = 0, wbeat = 0;
   logic [31:0] rd_addr = 32'h0;
   logic [15:0] lfsr = 16'hACE1;
   bit          ar_wait = 1'b0, w_wait = 1'b0;
   logic [31:0] ar_prev = 32'h0, w_prev = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   img_rot_engine u_img_rot_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .rd_base_i(rd_base), .wr_base_i(wr_base),
      .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
      .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_rready(m_rready),
      .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
      .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
      .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .next_line_o(m_next_line), .done_o(m_done)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'd2654435761) ^ 32'h3C5A_0F96;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // memory responder: everything decided at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (!rst_n) continue;
         // R10 hold checks against the previous falling edge
         if (ar_wait) chk(m_arvalid && m_araddr == ar_prev, "R10 AR hold", m_araddr, ar_prev);
         if (w_wait)  chk(m_wvalid && m_wdata == w_prev, "R10 W hold", m_wdata, w_prev);
         // read data
         if (rd_active) begin
            m_rvalid = stall ? lfsr[0] : 1'b1;
            m_rdata  = pat(rd_addr + 32'(rbeat * 4));
            if (m_rvalid && m_rready) begin
               rbeat++;
               if (rbeat == WORDS) rd_active = 1'b0;
            end
         end else begin
            m_rvalid = 1'b0;
         end
         // read address
         m_arready = stall ? lfsr[1] : 1'b1;
         ar_wait = m_arvalid && !m_arready;
         ar_prev = m_araddr;
         if (m_arvalid && m_arready) begin
            ar_fires++;
            chk(m_araddr == rd_base + 32'(exp_line * LB), "R3 araddr", m_araddr, rd_base + 32'(exp_line * LB));
            chk(m_arlen == 8'd63 && m_arsize == 3'd2 && m_arburst == 2'b01, "R3 ar fields",
                {19'd0, m_arlen, m_arsize, m_arburst}, {19'd0, 8'd63, 3'd2, 2'b01});
            chk(!line_busy, "R6 read before write response", {31'd0, line_busy}, 32'd0);
            rd_active = 1'b1; rbeat = 0; rd_addr = m_araddr; line_busy = 1'b1;
         end
         // write address
         m_awready = stall ? lfsr[2] : 1'b1;
         if (m_awvalid && m_awready) begin
            aw_fires++;
            chk(m_awaddr == wr_base + 32'(OUT_OFF + (LINES - 1 - exp_line) * LB), "R4 awaddr",
                m_awaddr, wr_base + 32'(OUT_OFF + (LINES - 1 - exp_line) * LB));
            chk(m_awlen == 8'd63 && m_awsize == 3'd2 && m_awburst == 2'b01, "R4 aw fields",
                {19'd0, m_awlen, m_awsize, m_awburst}, {19'd0, 8'd63, 3'd2, 2'b01});
            chk(!rd_active && rbeat == WORDS, "R6 write before read done", 32'(rbeat), 32'(WORDS));
            wbeat = 0;
         end
         // write data
         m_wready = stall ? lfsr[3] : 1'b1;
         w_wait = m_wvalid && !m_wready;
         w_prev = m_wdata;
         if (m_wvalid && m_wready) begin
            chk(m_wdata == pat(rd_base + 32'(exp_line * LB + (WORDS - 1 - wbeat) * 4)), "R5 reversed data",
                m_wdata, pat(rd_base + 32'(exp_line * LB + (WORDS - 1 - wbeat) * 4)));
            chk(m_wlast == (wbeat == WORDS - 1), "R5 wlast", {31'd0, m_wlast}, {31'd0, wbeat == WORDS - 1});
            chk(m_wstrb == 4'hF, "R5 wstrb", {28'd0, m_wstrb}, 32'hF);
            if (m_wlast) b_pending = 1'b1;
            wbeat++;
         end
         // write response
         if (b_pending) begin
            m_bvalid = stall ? lfsr[4] : 1'b1;
            m_bresp  = (inject && !injected && exp_line == 4) ? 2'b10 : 2'b00;
            if (m_bvalid && m_bready) begin
               b_pending = 1'b0;
               if (m_bresp != 2'b00) injected = 1'b1;
               else begin
                  exp_line++;
                  line_busy = 1'b0;
               end
            end
         end else begin
            m_bvalid = 1'b0;
         end
         if (m_next_line) begin
            nl_pulses++;
            chk(m_arvalid, "R8 next line with AR", {31'd0, m_arvalid}, 32'd1);
         end
         if (m_done && !done_seen) begin
            done_seen = 1'b1;
            chk(exp_line == LINES, "R9 done after last line", 32'(exp_line), 32'(LINES));
         end
      end
   end

   task automatic wait_done();
      for (int i = 0; i < 40000 && !m_done; i++) @(negedge clk);
      chk(m_done, "R9 run completes", {31'd0, m_done}, 32'd1);
   endtask

   task automatic clear_counts();
      exp_line = 0; ar_fires = 0; aw_fires = 0; nl_pulses = 0;
      done_seen = 1'b0; injected = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", exp_line, LINES);
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(!m_arvalid && !m_awvalid && !m_wvalid && !m_rready && !m_bready && !m_next_line && !m_done,
          "R1 reset outputs",
          {25'd0, m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready, m_next_line, m_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!m_arvalid && !m_done, "R1 after reset", {30'd0, m_arvalid, m_done}, 32'd0);

      // run 1: stalls, one error response, start edge while busy, start left high
      rd_base = 32'h1000_0000; wr_base = 32'h4000_0000;
      stall = 1'b1; inject = 1'b1; clear_counts();
      start_i = 1'b1;
      repeat (40) @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      wait_done();
      chk(ar_fires == LINES, "R2 one read per line", 32'(ar_fires), 32'(LINES));
      chk(injected, "R7 error injected", {31'd0, injected}, 32'd1);
      chk(aw_fires == LINES + 1, "R7 burst reissued", 32'(aw_fires), 32'(LINES + 1));
      chk(nl_pulses == LINES - 1, "R8 pulse count", 32'(nl_pulses), 32'(LINES - 1));
      repeat (100) @(negedge clk);
      chk(ar_fires == LINES, "R2 held level no restart", 32'(ar_fires), 32'(LINES));
      chk(m_done, "R9 done sticky", {31'd0, m_done}, 32'd1);

      // run 2: fresh bases, no stalls, no errors
      start_i = 1'b0;
      @(negedge clk);
      rd_base = 32'h0002_0000; wr_base = 32'h0100_0000;
      stall = 1'b0; inject = 1'b0; clear_counts();
      start_i = 1'b1;
      @(negedge clk);
      chk(!m_done, "R9 cleared by start edge", {31'd0, m_done}, 32'd0);
      wait_done();
      chk(ar_fires == LINES, "R6 reads in run 2", 32'(ar_fires), 32'(LINES));
      chk(aw_fires == LINES, "R4 writes in run 2", 32'(aw_fires), 32'(LINES));
      chk(nl_pulses == LINES - 1, "R8 pulses in run 2", 32'(nl_pulses), 32'(LINES - 1));
      summary();
      $finish;
   end
endmodule